// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one bus request from a 16-bit processor core into a complete external cycle on a bus that carries the low address and the data on the same 16 pins and has a 20-bit address. A request names the cycle kind, the address, byte or word size and the write data. The sequencer then steps through the phases T1, T2, T3 (repeated as wait states) and T4. It drives the status code, the address latch strobe, the read, write and data-enable strobes, the byte-high enable and the four upper address lines, and it returns read data.

Cycle length is set in one of two ways. In the first, T3 repeats until the bus READY input is seen high. In the second, READY is ignored and a wait count of 0 to 3, given with the request, sets how many extra T3 cycles are inserted. A word request at an odd address becomes two byte cycles run back to back: the odd byte at the given address first, then the even byte at the next address.

Top module: `mux_bus_seq`

## Requirements
- R1: The status code `stat_n` is driven during T1, T2 and T3 and is 3'b111 (passive) in idle and T4. Request kinds map to codes as 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 instruction fetch, 101 memory read, 110 memory write; kind 111 is a refresh cycle, shown with status 101.
- R2: `ale` is high for exactly the T1 cycle of each byte or word cycle and low at all other times.
- R3: During T1, `addr_hi` carries address bits 19:16 and `ad_out` carries address bits 15:0 with `ad_oe` high; outside T1 `addr_hi` is 0.
- R4: `rd_n` is low during T2 and T3 for I/O read, instruction fetch, memory read and refresh; `wr_n` is low during T2 and T3 for I/O write and memory write; the two are never low together.
- R5: `den_n` is low during T2 and T3 for every read or write kind and for interrupt acknowledge, and high otherwise, including halt cycles.
- R6: From T1 to T3 the pair {A0 (`ad_out[0]` in T1), `bhe_n`} is 00 for a word, 01 for an even byte, 10 for an odd byte and 11 for refresh; `bhe_n` is high in idle and T4.
- R7: With READY honoured, T3 repeats for as long as `bus_ready` is low at the clock edge and the cycle moves to T4 after the first edge where it is high.
- R8: With READY ignored, exactly `wait_cnt` extra T3 cycles are inserted whatever the level of `bus_ready`.
- R9: A word at an odd address runs two cycles: first an odd byte at the address, then an even byte at the address plus one (modulo 2^20); `done` rises only in the T4 of the second.
- R10: In T2 and T3 of a write, `ad_oe` is high and the data sits on its lane: a word on all 16 bits, an even byte on bits 7:0, an odd byte on bits 15:8 (zeros on the unused lane); in the second half of a split word the high data byte goes out on bits 7:0.
- R11: While `done` is high after a read, `rd_data` holds the data read: the full word, a byte zero-extended from its lane, or for a split word the odd-address byte in bits 7:0 and the even-address byte in bits 15:8.
- R12: After reset the sequencer is idle with all strobes inactive; `req_accept` is high only in idle, and a request is taken at a clock edge where `req_valid` and `req_accept` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind (see R1) |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | 16 | Write data, byte requests use bits 7:0 |
| no_ready_mode | input | 1 | 1 = ignore READY and use wait_cnt |
| wait_cnt | input | 2 | Wait states inserted when READY is ignored |
| req_accept | output | 1 | Sequencer idle, request can be taken |
| bus_ready | input | 1 | Bus ready from the addressed device |
| ad_in | input | 16 | Data read from the bus |
| ad_out | output | 16 | Address / write data driven onto the bus |
| ad_oe | output | 1 | Drive enable for ad_out |
| addr_hi | output | 4 | Upper address lines |
| stat_n | output | 3 | Bus status code |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data enable, active low |
| bhe_n | output | 1 | Byte-high enable, active low |
| done | output | 1 | Last T4 of the request |
| rd_data | output | 16 | Assembled read data, valid with done |

## Verification
Every bus output is decoded from the registered phase, so a request taken at one edge shows its T1 values for the whole following clock, and each later phase advances one clock at a time; READY is looked at only on the edge that ends a T3 cycle, and read data is captured on that same edge, appearing with `done` in T4. The bench builds the expected per-clock phase list for each request from its kind, address, size, wait mode and a planned READY stall count, drives `bus_ready` from that list, and compares all outputs once per clock one nanosecond after the falling edge, so every value is read in the middle of its phase.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic [DW-1:0] req_wdata,
  input  logic          no_ready_mode,
  input  logic [1:0]    wait_cnt,
  output logic          req_accept,
  input  logic          bus_ready,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic [2:0]    stat_n,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          bhe_n,
  output logic          done,
  output logic [DW-1:0] rd_data
);
  localparam int HB = DW / 2;

  typedef enum logic [2:0] {PH_IDLE, PH_T1, PH_T2, PH_T3, PH_T4} phase_t;

  phase_t        ph;
  logic [2:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic          word_q, split_q, half2_q, ign_q;
  logic [DW-1:0] wdata_q, rd_q;
  logic [1:0]    wc_q, wleft;

  wire refresh = (kind_q == 3'b111);
  wire is_rd   = (kind_q == 3'b001) || (kind_q == 3'b100) || (kind_q == 3'b101) || refresh;
  wire is_wr   = (kind_q == 3'b010) || (kind_q == 3'b110);
  wire is_den  = is_rd || is_wr || (kind_q == 3'b000);
  wire mid     = (ph == PH_T2) || (ph == PH_T3);
  wire active  = (ph == PH_T1) || mid;
  wire a0      = refresh ? 1'b1 : addr_q[0];
  wire full_w  = word_q && !split_q && !refresh;
  wire lane_hi = refresh ? 1'b0 : (full_w ? 1'b1 : addr_q[0]);

  wire [HB-1:0] bval   = half2_q ? wdata_q[DW-1:HB] : wdata_q[HB-1:0];
  wire [DW-1:0] wr_bus = full_w ? wdata_q :
                         addr_q[0] ? {bval, {HB{1'b0}}} : {{HB{1'b0}}, bval};
  wire advance = ign_q ? (wleft == 2'd0) : bus_ready;

  assign req_accept = (ph == PH_IDLE);
  assign stat_n  = active ? (refresh ? 3'b101 : kind_q) : 3'b111;
  assign ale     = (ph == PH_T1);
  assign addr_hi = (ph == PH_T1) ? addr_q[AW-1:DW] : '0;
  assign rd_n    = !(mid && is_rd);
  assign wr_n    = !(mid && is_wr);
  assign den_n   = !(mid && is_den);
  assign bhe_n   = active ? !lane_hi : 1'b1;
  assign ad_oe   = (ph == PH_T1) || (mid && is_wr);
  assign ad_out  = (ph == PH_T1) ? {addr_q[DW-1:1], a0} : wr_bus;
  assign done    = (ph == PH_T4) && (!split_q || half2_q);
  assign rd_data = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      kind_q  <= 3'b011;
      addr_q  <= '0;
      word_q  <= 1'b0;
      split_q <= 1'b0;
      half2_q <= 1'b0;
      ign_q   <= 1'b0;
      wdata_q <= '0;
      rd_q    <= '0;
      wc_q    <= '0;
      wleft   <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (req_valid) begin
          ph      <= PH_T1;
          kind_q  <= req_kind;
          addr_q  <= req_addr;
          word_q  <= req_word;
          split_q <= req_word && req_addr[0] && (req_kind != 3'b111);
          half2_q <= 1'b0;
          ign_q   <= no_ready_mode;
          wc_q    <= wait_cnt;
          wdata_q <= req_wdata;
        end
        PH_T1: ph <= PH_T2;
        PH_T2: begin
          ph    <= PH_T3;
          wleft <= wc_q;
        end
        PH_T3: begin
          if (advance) begin
            ph <= PH_T4;
            if (half2_q)        rd_q[DW-1:HB] <= ad_in[HB-1:0];
            else if (full_w)    rd_q <= ad_in;
            else if (addr_q[0]) rd_q <= {{HB{1'b0}}, ad_in[DW-1:HB]};
            else                rd_q <= {{HB{1'b0}}, ad_in[HB-1:0]};
          end else if (ign_q) begin
            wleft <= wleft - 2'd1;
          end
        end
        PH_T4: begin
          if (split_q && !half2_q) begin
            half2_q <= 1'b1;
            addr_q  <= addr_q + 1'b1;
            ph      <= PH_T1;
          end else begin
            ph <= PH_IDLE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       den_n,
  input logic       ad_oe,
  input logic       req_accept,
  input logic [2:0] stat_n,
  input logic [3:0] addr_hi
);
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_status_in_t1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (stat_n != 3'b111));
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |-> (addr_hi == 4'd0));
  assert_no_rd_wr_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_den_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !den_n);
  assert_write_drives_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> (stat_n == 3'b111 && rd_n && wr_n && den_n && !ale));
endmodule

bind mux_bus_seq mux_bus_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .den_n(den_n), .ad_oe(ad_oe), .req_accept(req_accept),
  .stat_n(stat_n), .addr_hi(addr_hi)
);

// File: tb/test_mux_bus_seq.sv
`timescale 1ns/100ps
module test_mux_bus_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_word = 1'b0, no_ready_mode = 1'b0, bus_ready = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic [1:0] wait_cnt = '0;
  logic req_accept, ad_oe, ale, rd_n, wr_n, den_n, bhe_n, done;
  logic [15:0] ad_out, rd_data;
  logic [3:0] addr_hi;
  logic [2:0] stat_n;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
    .no_ready_mode(no_ready_mode), .wait_cnt(wait_cnt), .req_accept(req_accept),
    .bus_ready(bus_ready), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .stat_n(stat_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .den_n(den_n), .bhe_n(bhe_n), .done(done), .rd_data(rd_data)
  );

  typedef struct {
    logic [2:0] s;
    logic ale, rd_n, wr_n, den_n, bhe_n, oe, acc, done, chkrd, rdy;
    logic [3:0] ahi;
    logic [15:0] ad, rd;
    int tag;
  } ent_t;

  ent_t q[$];

  function automatic ent_t idle_ent();
    ent_t e;
    e.s = 3'b111; e.ale = 0; e.rd_n = 1; e.wr_n = 1; e.den_n = 1; e.bhe_n = 1;
    e.oe = 0; e.acc = 1; e.done = 0; e.chkrd = 0; e.rdy = 0; e.ahi = 0;
    e.ad = 0; e.rd = 0; e.tag = 12;
    return e;
  endfunction

  task automatic cmp(string rq, string fld, int act, int exp, int tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s (case R%0d) @%0t: actual=%0h expected=%0h", rq, fld, tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    ent_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front(); else e = idle_ent();
    bus_ready = e.rdy;
    req_valid = 1'b0;
    #1;
    cmp("R1", "stat_n", stat_n, e.s, e.tag);
    cmp("R2", "ale", ale, e.ale, e.tag);
    cmp("R3", "addr_hi", addr_hi, e.ahi, e.tag);
    cmp("R4", "rd_n", rd_n, e.rd_n, e.tag);
    cmp("R4", "wr_n", wr_n, e.wr_n, e.tag);
    cmp("R5", "den_n", den_n, e.den_n, e.tag);
    cmp("R6", "bhe_n", bhe_n, e.bhe_n, e.tag);
    cmp("R10", "ad_oe", ad_oe, e.oe, e.tag);
    if (e.oe) cmp(e.ale ? "R3" : "R10", "ad_out", ad_out, e.ad, e.tag);
    cmp("R12", "req_accept", req_accept, e.acc, e.tag);
    cmp("R9", "done", done, e.done, e.tag);
    if (e.done && e.chkrd) cmp("R11", "rd_data", rd_data, e.rd, e.tag);
  endtask

  function automatic logic [2:0] stat_of(logic [2:0] k);
    return (k == 3'b111) ? 3'b101 : k;
  endfunction
  function automatic bit reads(logic [2:0] k);
    case (k) 3'b001, 3'b100, 3'b101, 3'b111: return 1; default: return 0; endcase
  endfunction
  function automatic bit writes(logic [2:0] k);
    case (k) 3'b010, 3'b110: return 1; default: return 0; endcase
  endfunction

  task automatic push_half(logic [2:0] k, logic [19:0] a, logic a0, logic lhi,
                           logic [15:0] lane, bit ign, int wc, int stall,
                           bit last, logic [15:0] rexp, int tag);
    ent_t e;
    bit rdk = reads(k), wrk = writes(k);
    bit denk = rdk || wrk || (k == 3'b000);
    int n = ign ? wc + 1 : stall + 1;
    e = idle_ent(); e.acc = 0; e.tag = tag;
    e.s = stat_of(k); e.ale = 1; e.ahi = a[19:16]; e.oe = 1;
    e.ad = {a[15:1], a0}; e.bhe_n = !lhi;
    q.push_back(e);
    e.ale = 0; e.ahi = 0; e.rd_n = !rdk; e.wr_n = !wrk; e.den_n = !denk;
    e.oe = wrk; e.ad = lane;
    q.push_back(e);
    for (int i = 0; i < n; i++) begin
      e.rdy = ign ? 1'b0 : (i == stall);
      q.push_back(e);
    end
    e = idle_ent(); e.acc = 0; e.tag = tag;
    e.done = last; e.chkrd = rdk && (k != 3'b111); e.rd = rexp;
    q.push_back(e);
  endtask

  task automatic issue(logic [2:0] k, logic [19:0] a, bit w, logic [15:0] wd,
                       bit ign, int wc, int stall, logic [15:0] din, int tag);
    bit rf = (k == 3'b111);
    req_kind = k; req_addr = a; req_word = w; req_wdata = wd;
    no_ready_mode = ign; wait_cnt = wc[1:0]; ad_in = din; req_valid = 1'b1;
    if (w && a[0] && !rf) begin
      push_half(k, a, 1'b1, 1'b1, {wd[7:0], 8'h00}, ign, wc, stall, 0, 16'h0, tag);
      push_half(k, a + 20'd1, 1'b0, 1'b0, {8'h00, wd[15:8]}, ign, wc, stall, 1,
                {din[7:0], din[15:8]}, tag);
    end else if (rf)
      push_half(k, a, 1'b1, 1'b0, 16'h0, ign, wc, stall, 1, 16'h0, tag);
    else if (w)
      push_half(k, a, 1'b0, 1'b1, wd, ign, wc, stall, 1, din, tag);
    else if (a[0])
      push_half(k, a, 1'b1, 1'b1, {wd[7:0], 8'h00}, ign, wc, stall, 1, {8'h00, din[15:8]}, tag);
    else
      push_half(k, a, 1'b0, 1'b0, {8'h00, wd[7:0]}, ign, wc, stall, 1, {8'h00, din[7:0]}, tag);
    while (q.size() > 0) tick();
    tick();
  endtask

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();              // R12 reset state
    rst_n = 1'b1;
    tick();
    issue(3'b101, 20'hA1234, 1, 16'h0, 0, 0, 0, 16'hBEEF, 7);   // R7 memory read word
    issue(3'b110, 20'h3_0010, 0, 16'h00C3, 0, 0, 2, 16'h0, 7);  // R7 stall, R10 even byte
    issue(3'b001, 20'h0_0451, 0, 16'h0, 1, 3, 0, 16'h5AA5, 8);  // R8 odd byte read
    issue(3'b010, 20'hF_8002, 1, 16'h1357, 1, 0, 0, 16'h0, 8);  // R8 zero waits
    issue(3'b100, 20'h2_1001, 1, 16'h0, 0, 0, 1, 16'h9C3E, 9);  // R9 split fetch
    issue(3'b110, 20'h5_FFFF, 1, 16'hA55A, 1, 2, 0, 16'h0, 9);  // R9 split write, carry
    issue(3'b101, 20'hFFFFF, 1, 16'h0, 0, 0, 0, 16'h1234, 9);   // R9 address wrap
    issue(3'b111, 20'h0_0040, 1, 16'h0, 0, 0, 1, 16'h0, 6);     // R6 refresh
    issue(3'b000, 20'h0_0000, 0, 16'h0, 1, 1, 0, 16'h0, 5);     // R5 interrupt acknowledge
    issue(3'b011, 20'h7_0000, 0, 16'h0, 0, 0, 0, 16'h0, 5);     // R5 halt
    issue(3'b010, 20'h6_0007, 0, 16'h00E1, 0, 0, 3, 16'h0, 10); // R10 odd byte write
    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule